// File: doc/BRIEF.md
# One-Bit Echo Buffer with Rotating Filter Alignment

This block holds the most recent radar echoes, each reduced to one bit per range sample, as a bank of column shift registers. It feeds a coincidence-counting correlator that compares a row of echo data against the matching row of a one-bit filter. A new echo arrives serially and overwrites the oldest column in place, in a slot picked by a modulo counter. The stored data is never moved sideways. Instead, the much smaller filter matrix is re-indexed, so that its column order turns by one place for each completed echo.

Range alignment is done along the columns. Each range-shift strobe rotates every data column by one row. A small counter reports how many range steps have been taken since the last echo bit was written. A combinational row selector presents one row of the data matrix, and the filter row aligned to it, as two parallel words for the downstream exclusive-or and counting stage. The filter is preloaded in parallel as a single wide word.

Top module: `echo_rotbuf`

## Requirements
- R1: After reset, the write slot and the range position are zero, and every data bit and every filter bit reads zero on all rows.
- R2: Each echo-write strobe shifts the echo bit into the column at the current write slot, entering at the top row, while that column moves down by one row. After DEPTH strobes, the bit written i-th (counting from 0) sits in row i.
- R3: The write slot advances by one after every DEPTH-th echo-write strobe and wraps from NCOL-1 to 0. It changes at no other time.
- R4: An echo write changes only the column at the current write slot. All other data columns keep their contents.
- R5: A range shift rotates every data column by one row: row r takes the old row r+1, and the top row takes the old row 0.
- R6: The range position counts range shifts modulo DEPTH and holds when there is no strobe.
- R7: An echo-write strobe clears the range position. A range shift in the same cycle is ignored: no column rotates and the position ends at zero.
- R8: A filter load stores filter column c, row r from input bit c*DEPTH+r. The filter output bit k shows filter column (k - write_slot) mod NCOL at the selected row.
- R9: Echo writes and range shifts leave the filter contents unchanged. A filter load may coincide with an echo write, and both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| echo_wr | input | 1 | Echo bit write strobe |
| echo_bit | input | 1 | Serial one-bit echo sample |
| rng_shift | input | 1 | Range shift strobe |
| filt_load | input | 1 | Parallel filter preload strobe |
| filt_data | input | NCOL*DEPTH | Filter preload word, column-major |
| row_sel | input | clog2(DEPTH) | Row presented on the outputs |
| data_row | output | NCOL | Selected data row, bit k from slot k |
| filt_row | output | NCOL | Filter row aligned to the data slots |
| wr_slot | output | clog2(NCOL) | Slot receiving the current echo |
| range_pos | output | clog2(DEPTH) | Range shifts since the last echo write, modulo DEPTH |

## Verification
An echo-write strobe and a range-shift strobe can arrive in the same cycle. The bench provokes this partway through an echo, after a few range steps, when the counter is non-zero and the columns are already rotated. It then judges the result by sweeping every row: no column may have rotated, only the slot column may have taken the new bit, and the range position must read zero. A filter load is also issued together with an echo write, and both effects are checked on the filter and data rows. Every echo, shift and load is compared against a bench model built from the requirements, including the wrap of the write slot past the last column.

// File: rtl/echo_rotbuf_pkg.sv
package echo_rotbuf_pkg;

  localparam int DEF_COLS  = 8;
  localparam int DEF_DEPTH = 16;

  // width of an index over n items, never below one bit
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // filter column aligned to data slot k for write pointer wp
  function automatic int rot_index(input int k, input int wp, input int n);
    return (k >= wp) ? (k - wp) : (k + n - wp);
  endfunction

endpackage

// File: rtl/ebuf_ctrl.sv
module ebuf_ctrl
  import echo_rotbuf_pkg::*;
#(
  parameter int NCOL  = DEF_COLS,
  parameter int DEPTH = DEF_DEPTH,
  localparam int CW   = idx_w(NCOL),
  localparam int RW   = idx_w(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          echo_wr,
  input  logic          rng_shift,
  output logic [CW-1:0] wr_slot,
  output logic [RW-1:0] range_pos,
  output logic          shift_go
);

  localparam logic [CW-1:0] SLOT_LAST = CW'(NCOL - 1);
  localparam logic [RW-1:0] ROW_LAST  = RW'(DEPTH - 1);

  logic [RW-1:0] bit_cnt_q, bit_cnt_d;
  logic [CW-1:0] slot_q, slot_d;
  logic [RW-1:0] rng_q, rng_d;

  always_comb begin
    bit_cnt_d = bit_cnt_q;
    slot_d    = slot_q;
    rng_d     = rng_q;
    if (echo_wr) begin
      rng_d = '0;
      if (bit_cnt_q == ROW_LAST) begin
        bit_cnt_d = '0;
        slot_d    = (slot_q == SLOT_LAST) ? '0 : slot_q + 1'b1;
      end else begin
        bit_cnt_d = bit_cnt_q + 1'b1;
      end
    end else if (rng_shift) begin
      rng_d = (rng_q == ROW_LAST) ? '0 : rng_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt_q <= '0;
      slot_q    <= '0;
      rng_q     <= '0;
    end else begin
      bit_cnt_q <= bit_cnt_d;
      slot_q    <= slot_d;
      rng_q     <= rng_d;
    end
  end

  assign wr_slot   = slot_q;
  assign range_pos = rng_q;
  assign shift_go  = rng_shift & ~echo_wr;

  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !echo_wr |=> $stable(wr_slot)); // R3
  AST_SLOT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    wr_slot <= SLOT_LAST); // R3
  AST_RANGE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    echo_wr |=> (range_pos == '0)); // R7
  AST_RANGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!echo_wr && !rng_shift) |=> $stable(range_pos)); // R6

endmodule

// File: rtl/ebuf_col.sv
module ebuf_col
  import echo_rotbuf_pkg::*;
#(
  parameter int DEPTH = DEF_DEPTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_bit,
  input  logic             rot_en,
  output logic [DEPTH-1:0] q
);

  logic [DEPTH-1:0] col_q, col_d;

  always_comb begin
    col_d = col_q;
    if (wr_en) begin
      col_d = {wr_bit, col_q[DEPTH-1:1]};
    end else if (rot_en) begin
      col_d = {col_q[0], col_q[DEPTH-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= '0;
    end else if (wr_en || rot_en) begin
      col_q <= col_d;
    end
  end

  assign q = col_q;

endmodule

// File: rtl/ebuf_data_cols.sv
module ebuf_data_cols
  import echo_rotbuf_pkg::*;
#(
  parameter int NCOL  = DEF_COLS,
  parameter int DEPTH = DEF_DEPTH,
  localparam int CW   = idx_w(NCOL),
  localparam int RW   = idx_w(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            echo_wr,
  input  logic            echo_bit,
  input  logic [CW-1:0]   wr_slot,
  input  logic            shift_go,
  input  logic [RW-1:0]   row_sel,
  output logic [NCOL-1:0] data_row
);

  logic [DEPTH-1:0] col_q [NCOL];

  for (genvar k = 0; k < NCOL; k++) begin : g_col
    logic wr_en_k;
    assign wr_en_k = echo_wr && (wr_slot == CW'(k));

    ebuf_col #(.DEPTH(DEPTH)) u_col (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en_k),
      .wr_bit (echo_bit),
      .rot_en (shift_go),
      .q      (col_q[k])
    );

    assign data_row[k] = col_q[k][row_sel];

    AST_OTHER_COL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (echo_wr && (wr_slot != CW'(k))) |=> $stable(col_q[k])); // R4
    AST_ROTATE_KEEPS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_go && !echo_wr) |=> ($countones(col_q[k]) == $countones($past(col_q[k])))); // R5
    AST_IDLE_COL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!echo_wr && !shift_go) |=> $stable(col_q[k])); // R7
  end

endmodule

// File: rtl/ebuf_filt.sv
module ebuf_filt
  import echo_rotbuf_pkg::*;
#(
  parameter int NCOL  = DEF_COLS,
  parameter int DEPTH = DEF_DEPTH,
  localparam int CW   = idx_w(NCOL),
  localparam int RW   = idx_w(DEPTH),
  localparam int FBITS = NCOL * DEPTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             filt_load,
  input  logic [FBITS-1:0] filt_data,
  input  logic [CW-1:0]    wr_slot,
  input  logic [RW-1:0]    row_sel,
  output logic [NCOL-1:0]  filt_row
);

  logic [FBITS-1:0] coef_q, coef_d;

  always_comb begin
    coef_d = coef_q;
    if (filt_load) begin
      coef_d = filt_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coef_q <= '0;
    end else if (filt_load) begin
      coef_q <= coef_d;
    end
  end

  // rotating alignment: slot k reads filter column (k - wr_slot) mod NCOL
  always_comb begin
    for (int k = 0; k < NCOL; k++) begin
      filt_row[k] = coef_q[rot_index(k, int'(wr_slot), NCOL) * DEPTH + int'(row_sel)];
    end
  end

  AST_FILT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !filt_load |=> $stable(coef_q)); // R9
  AST_FILT_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    filt_load |=> (coef_q == $past(filt_data))); // R8

endmodule

// File: rtl/echo_rotbuf.sv
module echo_rotbuf
  import echo_rotbuf_pkg::*;
#(
  parameter int NCOL  = DEF_COLS,
  parameter int DEPTH = DEF_DEPTH,
  localparam int CW   = idx_w(NCOL),
  localparam int RW   = idx_w(DEPTH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  echo_wr,
  input  logic                  echo_bit,
  input  logic                  rng_shift,
  input  logic                  filt_load,
  input  logic [NCOL*DEPTH-1:0] filt_data,
  input  logic [RW-1:0]         row_sel,
  output logic [NCOL-1:0]       data_row,
  output logic [NCOL-1:0]       filt_row,
  output logic [CW-1:0]         wr_slot,
  output logic [RW-1:0]         range_pos
);

  logic [1:0] rst_sync_q;
  logic       rst_n_s;
  logic       shift_go;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_s = rst_sync_q[1];

  ebuf_ctrl #(.NCOL(NCOL), .DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .echo_wr   (echo_wr),
    .rng_shift (rng_shift),
    .wr_slot   (wr_slot),
    .range_pos (range_pos),
    .shift_go  (shift_go)
  );

  ebuf_data_cols #(.NCOL(NCOL), .DEPTH(DEPTH)) u_data (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .echo_wr  (echo_wr),
    .echo_bit (echo_bit),
    .wr_slot  (wr_slot),
    .shift_go (shift_go),
    .row_sel  (row_sel),
    .data_row (data_row)
  );

  ebuf_filt #(.NCOL(NCOL), .DEPTH(DEPTH)) u_filt (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .filt_load (filt_load),
    .filt_data (filt_data),
    .wr_slot   (wr_slot),
    .row_sel   (row_sel),
    .filt_row  (filt_row)
  );

  AST_SHIFT_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n_s)
    echo_wr |-> !shift_go); // R7

endmodule

// File: tb/echo_rotbuf_tb.sv
module echo_rotbuf_tb;

  localparam int P = 8;
  localparam int D = 16;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           echo_wr, echo_bit, rng_shift, filt_load;
  logic [P*D-1:0] filt_data;
  logic [3:0]     row_sel;
  logic [P-1:0]   data_row, filt_row;
  logic [2:0]     wr_slot;
  logic [3:0]     range_pos;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  bit mdata [P][D];
  bit mfilt [P][D];
  int mwp  = 0;
  int mcnt = 0;
  int mrng = 0;

  always #10ns clk = ~clk;

  echo_rotbuf u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .echo_wr   (echo_wr),
    .echo_bit  (echo_bit),
    .rng_shift (rng_shift),
    .filt_load (filt_load),
    .filt_data (filt_data),
    .row_sel   (row_sel),
    .data_row  (data_row),
    .filt_row  (filt_row),
    .wr_slot   (wr_slot),
    .range_pos (range_pos)
  );

  function automatic bit ebit(input int e, input int i);
    return bit'((((e * 7 + i * 5 + (i >> 2)) % 3) == 0) ^ (e & 1));
  endfunction

  function automatic bit fpat(input int seed, input int c, input int r);
    return bit'(((c * 3 + r * 5 + c * r + seed) % 4) < 2);
  endfunction

  function automatic logic [P*D-1:0] fword(input int seed);
    logic [P*D-1:0] w;
    for (int c = 0; c < P; c++)
      for (int r = 0; r < D; r++)
        w[c*D + r] = fpat(seed, c, r);
    return w;
  endfunction

  task automatic check_val(input string tag, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got %0d exp %0d", tag, what, got, exp);
    end
  endtask

  // sweeps every row; strobes must be low
  task automatic check_all(input string tag);
    for (int r = 0; r < D; r++) begin
      logic [P-1:0] ed, ef;
      row_sel = 4'(r);
      #1ns;
      for (int k = 0; k < P; k++) begin
        ed[k] = mdata[k][r];
        ef[k] = mfilt[(k - mwp + P) % P][r];
      end
      checks++;
      if (data_row !== ed) begin
        errors++;
        $display("FAIL %s data row %0d got %b exp %b", tag, r, data_row, ed);
      end
      checks++;
      if (filt_row !== ef) begin
        errors++;
        $display("FAIL %s filter row %0d got %b exp %b", tag, r, filt_row, ef);
      end
    end
    check_val(tag, "wr_slot", int'(wr_slot), mwp);
    check_val(tag, "range_pos", int'(range_pos), mrng);
  endtask

  task automatic step(input bit wr, input bit b, input bit sh, input bit fl, input logic [P*D-1:0] fd);
    @(negedge clk);
    echo_wr = wr; echo_bit = b; rng_shift = sh; filt_load = fl; filt_data = fd;
    @(posedge clk);
    if (wr) begin
      for (int r = 0; r < D - 1; r++) mdata[mwp][r] = mdata[mwp][r+1];
      mdata[mwp][D-1] = b;
      mrng = 0;
      if (mcnt == D - 1) begin
        mcnt = 0;
        mwp  = (mwp + 1) % P;
      end else begin
        mcnt++;
      end
    end else if (sh) begin
      for (int k = 0; k < P; k++) begin
        bit t;
        t = mdata[k][0];
        for (int r = 0; r < D - 1; r++) mdata[k][r] = mdata[k][r+1];
        mdata[k][D-1] = t;
      end
      mrng = (mrng + 1) % D;
    end
    if (fl)
      for (int c = 0; c < P; c++)
        for (int r = 0; r < D; r++) mfilt[c][r] = fd[c*D + r];
    @(negedge clk);
    echo_wr = 1'b0; rng_shift = 1'b0; filt_load = 1'b0;
  endtask

  task automatic write_echo(input int e);
    for (int i = 0; i < D; i++) step(1'b1, ebit(e, i), 1'b0, 1'b0, filt_data);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    echo_wr = 1'b0; echo_bit = 1'b0; rng_shift = 1'b0; filt_load = 1'b0;
    filt_data = '0; row_sel = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    check_all("R1 reset");

    step(1'b0, 1'b0, 1'b0, 1'b1, fword(1));
    check_all("R8 filter load");

    for (int e = 0; e < 10; e++) begin
      write_echo(e);
      check_all("R2 R3 R4 R8 echo");
    end

    // partial echo, range steps, then collision of write and shift
    for (int i = 0; i < 5; i++) step(1'b1, ebit(10, i), 1'b0, 1'b0, filt_data);
    for (int s = 0; s < 3; s++) step(1'b0, 1'b0, 1'b1, 1'b0, filt_data);
    check_all("R5 R6 before collision");
    step(1'b1, ebit(10, 5), 1'b1, 1'b0, filt_data);
    check_all("R7 write over shift");
    for (int i = 6; i < D; i++) step(1'b1, ebit(10, i), 1'b0, 1'b0, filt_data);
    check_all("R3 R4 echo after collision");

    // range sweep past wrap
    for (int s = 0; s < D + 4; s++) begin
      step(1'b0, 1'b0, 1'b1, 1'b0, filt_data);
      check_all("R5 R6 R9 range shift");
    end

    // filter load together with an echo bit
    step(1'b1, 1'b1, 1'b0, 1'b1, fword(3));
    check_all("R9 R8 load with write");
    for (int i = 1; i < D; i++) step(1'b1, ebit(11, i), 1'b0, 1'b0, filt_data);
    check_all("R3 R8 rotation after load");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule